// File: doc/BRIEF.md
# Supervised SRAM Access Gate

This block sits between a host bus and an external static RAM that shares its address space with a small window of internal timekeeping registers. The host presents a 19-bit address with active-low chip, output and write enables. The block decides whether each access goes to the RAM or to the register file. It drives a gated chip enable and output enable to the RAM, and a select with write/read strobes and a register index to the register file.

The top sixteen addresses form the register window. An access there never enables the RAM, and the RAM's output enable stays inactive, so the two sources cannot both drive the data bus. A digital power-fail input write-protects both targets. The decision is taken once, when a bus cycle begins, and is held until chip enable returns high. A cycle that started while power was good therefore completes, and a cycle that started during a power fault stays blocked to its end.

Top module: `sram_access_gate`

## Requirements
- R1: While `ceN` is high, `ramCeN` and `ramOeN` are high, and `regSel`, `regWr`, `regRd` and `dataOutEn` are low, whatever the other inputs are.
- R2: With `ceN` low, `weN` low, an address outside the window and the cycle not blocked, `ramCeN` is low and `ramOeN` is high whatever `oeN` is. This is a RAM write.
- R3: With `ceN` low, `oeN` low, `weN` high, an address outside the window and the cycle not blocked, `ramCeN` and `ramOeN` are both low and `dataOutEn` is high. This is a RAM read.
- R4: With `ceN` low and both `oeN` and `weN` high, `ramOeN` is high and `dataOutEn` is low. `ramCeN` still follows the address decode.
- R5: The addresses 0x7FFF0 to 0x7FFFF (address bits 18..4 all ones) select the register file. For an unblocked cycle to one of them, `regSel` is high, `ramCeN` and `ramOeN` are high, and `regIdx` equals address bits 3..0.
- R6: In an unblocked register cycle, `regWr` is high when `weN` is low and `regRd` is high when `oeN` is low with `weN` high. The two are never high together, and `dataOutEn` is high on a register read.
- R7: If `pwrFail` is high in the clock period where a cycle begins, the whole cycle is blocked. `ramCeN`, `ramOeN` and the register strobes stay inactive until `ceN` returns high, even if `pwrFail` clears.
- R8: If `pwrFail` rises after a cycle has begun unblocked, the cycle keeps running normally until `ceN` returns high.
- R9: A cycle begins in the first clock period in which `ceN` is low after it was high at the previous rising clock edge. The block decision uses `pwrFail` in that period, not its earlier value.
- R10: While `rstN` is low, every access is blocked. After reset, the first period with `ceN` low begins a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 19 | Host address |
| ceN | input | 1 | Host chip enable, active low |
| oeN | input | 1 | Host output enable, active low |
| weN | input | 1 | Host write enable, active low |
| pwrFail | input | 1 | Supply out of tolerance, active high |
| ramCeN | output | 1 | Gated chip enable to external RAM, active low |
| ramOeN | output | 1 | Gated output enable to external RAM, active low |
| regSel | output | 1 | Register file selected |
| regWr | output | 1 | Register write strobe |
| regRd | output | 1 | Register read strobe |
| regIdx | output | 4 | Register index within the window |
| dataOutEn | output | 1 | The data bus is driven by RAM or the register file |

## Verification
Every output is combinational from the present inputs and two state bits that update on the rising edge. A stimulus applied at a falling edge therefore shows its result in the same half period. The bench drives at the falling edge and samples one nanosecond later, before the next rising edge. The held block decision only shows in the periods after a cycle start. The R7 and R8 sequences therefore check each period of a multi-period cycle separately after the intervening edge.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2,
    ACC_QUIET = 2'd3
  } accKind_t;

  typedef struct packed {
    logic live;
    logic write;
    logic read;
  } gateStrobes_t;

endpackage

// File: rtl/sram_gate_ctrl.sv
module sram_gate_ctrl
  import sram_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ceN,
  input  logic         oeN,
  input  logic         weN,
  input  logic         pwrFail,
  output gateStrobes_t strobes
);

  logic     prevCeN;
  logic     holdBlock;
  logic     cycleStart;
  logic     blockNow;
  accKind_t kind;

  // a cycle opens when ceN is low now but was high at the last edge
  assign cycleStart = !ceN && prevCeN;
  assign blockNow   = !rstN || (cycleStart ? pwrFail : holdBlock);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCeN   <= 1'b1;
      holdBlock <= 1'b1;
    end else begin
      prevCeN <= ceN;
      if (cycleStart) holdBlock <= pwrFail;
    end
  end

  always_comb begin
    if (ceN)        kind = ACC_IDLE;
    else if (!weN)  kind = ACC_WRITE;
    else if (!oeN)  kind = ACC_READ;
    else            kind = ACC_QUIET;
  end

  always_comb begin
    strobes.live  = (kind != ACC_IDLE) && !blockNow;
    strobes.write = strobes.live && (kind == ACC_WRITE);
    strobes.read  = strobes.live && (kind == ACC_READ);
  end

endmodule

// File: rtl/sram_gate_datapath.sv
module sram_gate_datapath
  import sram_gate_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int WIN_BITS = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  gateStrobes_t        strobes,
  output logic                ramCeN,
  output logic                ramOeN,
  output logic                regSel,
  output logic                regWr,
  output logic                regRd,
  output logic [WIN_BITS-1:0] regIdx,
  output logic                dataOutEn
);

  localparam int HIGH_W = ADDR_W - WIN_BITS;

  logic [HIGH_W-1:0] upperBits;
  logic              regHit;

  assign upperBits = addr[ADDR_W-1:WIN_BITS];
  assign regHit    = &upperBits;
  assign regIdx    = addr[WIN_BITS-1:0];

  assign ramCeN    = !(strobes.live && !regHit);
  assign ramOeN    = !(strobes.read && !regHit);
  assign regSel    = strobes.live && regHit;
  assign regWr     = strobes.write && regHit;
  assign regRd     = strobes.read && regHit;
  assign dataOutEn = strobes.read;

endmodule

// File: rtl/sram_access_gate.sv
module sram_access_gate
  import sram_gate_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int WIN_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ceN,
  input  logic                oeN,
  input  logic                weN,
  input  logic                pwrFail,
  output logic                ramCeN,
  output logic                ramOeN,
  output logic                regSel,
  output logic                regWr,
  output logic                regRd,
  output logic [WIN_BITS-1:0] regIdx,
  output logic                dataOutEn
);

  gateStrobes_t strobes;

  sram_gate_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .oeN     (oeN),
    .weN     (weN),
    .pwrFail (pwrFail),
    .strobes (strobes)
  );

  sram_gate_datapath #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS)
  ) i_datapath (
    .addr      (addr),
    .strobes   (strobes),
    .ramCeN    (ramCeN),
    .ramOeN    (ramOeN),
    .regSel    (regSel),
    .regWr     (regWr),
    .regRd     (regRd),
    .regIdx    (regIdx),
    .dataOutEn (dataOutEn)
  );

endmodule

// File: rtl/sram_access_gate_checker.sv
module sram_access_gate_checker #(
  parameter int ADDR_W   = 19,
  parameter int WIN_BITS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                ceN,
  input logic                oeN,
  input logic                weN,
  input logic                pwrFail,
  input logic                ramCeN,
  input logic                ramOeN,
  input logic                regSel,
  input logic                regWr,
  input logic                regRd,
  input logic [WIN_BITS-1:0] regIdx,
  input logic                dataOutEn
);

  logic inWindow;
  assign inWindow = &addr[ADDR_W-1:WIN_BITS];

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (ramCeN && ramOeN && !regSel && !regWr && !regRd && !dataOutEn));

  assert_write_no_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> ramOeN);

  assert_read_opens_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && $past(ceN) && !oeN && weN && !pwrFail && !inWindow) |-> (!ramCeN && !ramOeN && dataOutEn));

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (oeN && weN) |-> (ramOeN && !dataOutEn));

  assert_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> (ramCeN && ramOeN && inWindow && regIdx == addr[WIN_BITS-1:0]));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));

  assert_block_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && $past(ceN) && pwrFail) |-> (ramCeN && !regSel));

  assert_block_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && $past(!ceN) && $past(rstN) && $past(ramCeN && !regSel)) |-> (ramCeN && !regSel));

  assert_finish_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && $past(!ceN) && $past(rstN) && $past(!ramCeN || regSel)) |-> (!ramCeN || regSel));

  assert_reset_block_R10: assert property (@(posedge clk)
    !rstN |-> (ramCeN && ramOeN && !regSel && !dataOutEn));

endmodule

bind sram_access_gate sram_access_gate_checker #(
  .ADDR_W   (ADDR_W),
  .WIN_BITS (WIN_BITS)
) i_checker (.*);

// File: tb/test_sram_access_gate.sv
`timescale 1ns/1ps
module test_sram_access_gate;

  logic        clk = 1'b0;
  logic        rstN;
  logic [18:0] addr;
  logic        ceN, oeN, weN, pwrFail;
  logic        ramCeN, ramOeN, regSel, regWr, regRd, dataOutEn;
  logic [3:0]  regIdx;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sram_access_gate i_sram_access_gate (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pwrFail(pwrFail), .ramCeN(ramCeN), .ramOeN(ramOeN), .regSel(regSel),
    .regWr(regWr), .regRd(regRd), .regIdx(regIdx), .dataOutEn(dataOutEn)
  );

  // {ramCeN, ramOeN, regSel, regWr, regRd, dataOutEn, regIdx}
  function automatic logic [9:0] expOut(logic [18:0] a, logic ce, logic oe,
                                        logic we, logic live);
    logic hit, act, wr, rd;
    hit = (a[18:4] == 15'h7FFF);
    act = !ce && live;
    wr  = act && !we;
    rd  = act && we && !oe;
    return {!(act && !hit), !(rd && !hit), act && hit, wr && hit,
            rd && hit, rd, a[3:0]};
  endfunction

  task automatic drive(logic ce, logic oe, logic we, logic pf, logic [18:0] a);
    @(negedge clk);
    ceN = ce; oeN = oe; weN = we; pwrFail = pf; addr = a;
    #1;
  endtask

  task automatic check(string tag, logic [9:0] exp);
    logic [9:0] act;
    act = {ramCeN, ramOeN, regSel, regWr, regRd, dataOutEn, regIdx};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b addr=%h", tag, act, exp, addr);
    end
  endtask

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [18:0] alist [8];
    alist = '{19'h00000, 19'h00001, 19'h7FFEF, 19'h3FFFF,
              19'h7FFE0, 19'h55555, 19'h7FFF0, 19'h7FFFF};
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; pwrFail = 1'b0; addr = '0;
    // R10: reset blocks even a low ceN
    drive(1, 0, 1, 0, 19'h00010);
    check("R10", expOut(19'h00010, 1, 0, 1, 0));
    drive(0, 0, 1, 0, 19'h00010);
    check("R10", expOut(19'h00010, 0, 0, 1, 0));
    drive(1, 1, 1, 0, 19'h00010);
    @(negedge clk); rstN = 1'b1;
    // R10: first low ceN after reset starts an unblocked cycle
    drive(0, 0, 1, 0, 19'h00020);
    check("R10", expOut(19'h00020, 0, 0, 1, 1));

    // sweep: full window plus outside addresses, all enable combos, power state
    for (int i = 0; i < 24; i++) begin
      logic [18:0] a;
      a = (i < 16) ? {15'h7FFF, i[3:0]} : alist[i-16];
      for (int m = 0; m < 8; m++) begin
        logic oe, we, pf, hit;
        string tag;
        oe = m[0]; we = m[1]; pf = m[2];
        hit = (a[18:4] == 15'h7FFF);
        drive(1, oe, we, pf, a);
        check("R1", expOut(a, 1, oe, we, 1));
        drive(0, oe, we, pf, a);
        if (pf) tag = "R7";
        else if (hit && !(oe && we)) tag = "R6";
        else if (hit) tag = "R5";
        else if (!we) tag = "R2";
        else if (!oe) tag = "R3";
        else tag = "R4";
        check(tag, expOut(a, 0, oe, we, !pf));
      end
    end

    // R7: blocked cycle stays blocked after pwrFail clears
    drive(1, 1, 1, 0, 19'h01000);
    drive(0, 1, 0, 1, 19'h01000);
    check("R7", expOut(19'h01000, 0, 1, 0, 0));
    drive(0, 1, 0, 0, 19'h01000);
    check("R7", expOut(19'h01000, 0, 1, 0, 0));
    drive(0, 0, 1, 0, 19'h7FFF3);
    check("R7", expOut(19'h7FFF3, 0, 0, 1, 0));
    drive(1, 1, 1, 0, 19'h01000);
    drive(0, 0, 1, 0, 19'h01000);
    check("R7", expOut(19'h01000, 0, 0, 1, 1));

    // R8: pwrFail rising mid-cycle does not truncate
    drive(1, 1, 1, 0, 19'h02000);
    drive(0, 1, 0, 0, 19'h02000);
    check("R8", expOut(19'h02000, 0, 1, 0, 1));
    drive(0, 1, 0, 1, 19'h02000);
    check("R8", expOut(19'h02000, 0, 1, 0, 1));
    drive(0, 1, 0, 1, 19'h7FFF9);
    check("R8", expOut(19'h7FFF9, 0, 1, 0, 1));
    drive(1, 1, 0, 1, 19'h02000);
    check("R1", expOut(19'h02000, 1, 1, 0, 1));
    drive(0, 1, 0, 1, 19'h02000);
    check("R8", expOut(19'h02000, 0, 1, 0, 0));

    // R9: only pwrFail in the start period matters
    drive(1, 1, 1, 1, 19'h03000);
    drive(0, 0, 1, 0, 19'h03000);
    check("R9", expOut(19'h03000, 0, 0, 1, 1));
    drive(0, 0, 1, 1, 19'h03000);
    check("R9", expOut(19'h03000, 0, 0, 1, 1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule